// File: doc/BRIEF.md
# Iterative Booth Carry-Save Multiplier

This block multiplies two 32-bit operands into a 64-bit product over several clock cycles. A 64-bit value can optionally be added to the product. Each working cycle consumes one byte of the multiplier operand. The byte passes through four chained carry-save layers, and each layer applies radix-4 Booth recoding to two multiplier bits. The partial sum and the partial carry stay in redundant form between cycles. One carry-propagate add merges them at the end.

The caller pulses `start` while the block is idle, with the operands, a signed/unsigned select and an accumulate enable. The block raises `busy` until the result is ready. Then it presents the product and pulses `done`. The iteration stops early once the multiplier bits not yet consumed can add nothing through further Booth digits. That happens when they are all zero, or, for a signed operand, all one. Any leftover Booth carry is folded into the final add. A small multiplier therefore finishes in fewer cycles than a wide one.

Top module: `csa_iter_mul`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `product` is 0.
- R2: With `sgn`=0, the result is the unsigned 64-bit product of `op_a` and `op_b`.
- R3: With `sgn`=1, both operands are two's complement, and the result is their signed 64-bit product.
- R4: With `acc_en`=1, the result is the product plus `acc_in`, modulo 2^64. With `acc_en`=0, `acc_in` has no effect on the result.
- R5: Let n be the smallest i in 0..4 for which the bits of `op_b` from bit 8*i upward are all zero, or, with `sgn`=1, all zero or all one. If `start` is sampled at edge k, then `done` is high right after edge k+1+n. The worst case is therefore five cycles from start to done.
- R6: `busy` rises on the edge that accepts `start`. It stays high until the edge that raises `done`, and it is 0 whenever `done` is 1.
- R7: `done` is high for exactly one cycle per operation.
- R8: A `start` seen while `busy` is 1 is ignored. The running result is not disturbed, and no further operation begins.
- R9: `product` keeps its value from one `done` pulse to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; honoured only while not busy |
| sgn | input | 1 | 1 = signed operands, 0 = unsigned |
| acc_en | input | 1 | 1 = add acc_in to the product |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier, consumed one byte per cycle |
| acc_in | input | 64 | Accumulate addend |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 64 | Result |

## Verification
The bench computes the expected cycle count n from the multiplier operand and the signedness. It counts falling edges after the start edge and expects `done` exactly at count n+2. `busy` is expected at count 1, and the quiet state one cycle after `done`. All samples are taken at the falling edge, so every registered output has settled a half period after the edge that updates it. The expected product comes from plain 64-bit arithmetic in the bench, not from recoding. Random operands have their upper bytes forced to zero or one, so every early-exit point gets exercised.

// File: rtl/mulcs_pkg.sv
package mulcs_pkg;

  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_sel_t;

  typedef enum logic [1:0] {CORR_NONE, CORR_ADD, CORR_SUB} corr_t;

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  // Radix-4 Booth digit from {b[2j+1], b[2j], b[2j-1]}
  function automatic booth_sel_t booth_decode(input logic [2:0] g);
    booth_sel_t s;
    s = '0;
    case (g)
      3'b001, 3'b010: s.one = 1'b1;
      3'b011:         s.two = 1'b1;
      3'b100:         begin s.two = 1'b1; s.neg = 1'b1; end
      3'b101, 3'b110: begin s.one = 1'b1; s.neg = 1'b1; end
      default:        s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/booth_csa_layer.sv
module booth_csa_layer
  import mulcs_pkg::*;
#(
  parameter int P_W = 64
) (
  input  logic [P_W-1:0] sum_i,
  input  logic [P_W-1:0] carry_i,
  input  logic [P_W-1:0] mcand,
  input  logic [2:0]     grp,
  output logic [P_W-1:0] sum_o,
  output logic [P_W-1:0] carry_o
);

  // One's complement partial product; the +1 of a negative digit rides in carry bit 0
  function automatic logic [P_W-1:0] pp_vec(input booth_sel_t s, input logic [P_W-1:0] m);
    logic [P_W-1:0] mag;
    mag = s.two ? (m << 1) : (s.one ? m : '0);
    return s.neg ? ~mag : mag;
  endfunction

  booth_sel_t sel;
  logic [P_W-1:0] pp, maj;

  always_comb begin
    sel     = booth_decode(grp);
    pp      = pp_vec(sel, mcand);
    sum_o   = sum_i ^ carry_i ^ pp;
    maj     = (sum_i & carry_i) | (sum_i & pp) | (carry_i & pp);
    carry_o = {maj[P_W-2:0], sel.neg};
  end

endmodule

// File: rtl/csa_step.sv
module csa_step #(
  parameter int P_W  = 64,
  parameter int STEP = 8
) (
  input  logic [P_W-1:0]  sum_i,
  input  logic [P_W-1:0]  carry_i,
  input  logic [P_W-1:0]  mcand,
  input  logic [STEP-1:0] bits,
  input  logic            cin,
  output logic [P_W-1:0]  sum_o,
  output logic [P_W-1:0]  carry_o
);

  localparam int LAYERS = STEP / 2;

  logic [P_W-1:0] s_w [LAYERS+1];
  logic [P_W-1:0] c_w [LAYERS+1];
  logic [STEP:0]  ext;

  assign ext    = {bits, cin};
  assign s_w[0] = sum_i;
  assign c_w[0] = carry_i;

  for (genvar j = 0; j < LAYERS; j++) begin : g_layer
    booth_csa_layer #(.P_W(P_W)) u_layer (
      .sum_i  (s_w[j]),
      .carry_i(c_w[j]),
      .mcand  (mcand << (2 * j)),
      .grp    (ext[2*j +: 3]),
      .sum_o  (s_w[j+1]),
      .carry_o(c_w[j+1])
    );
  end

  assign sum_o   = s_w[LAYERS];
  assign carry_o = c_w[LAYERS];

endmodule

// File: rtl/term_detect.sv
module term_detect
  import mulcs_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic [OP_W-1:0] rem,
  input  logic            sgn,
  input  logic            cin,
  output logic            term,
  output corr_t           corr
);

  logic all0, all1;

  always_comb begin
    all0 = (rem == '0);
    all1 = sgn && (&rem);
    term = all0 || all1;
    corr = CORR_NONE;
    if (all0 && cin)       corr = CORR_ADD;   // pending +1 digit
    else if (all1 && !cin) corr = CORR_SUB;   // pending -1 digit
  end

endmodule

// File: rtl/csa_iter_mul.sv
module csa_iter_mul
  import mulcs_pkg::*;
#(
  parameter int OP_W = 32,
  parameter int STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sgn,
  input  logic              acc_en,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic [2*OP_W-1:0] acc_in,
  output logic              busy,
  output logic              done,
  output logic [2*OP_W-1:0] product
);

  localparam int P_W = 2 * OP_W;

  function automatic logic [P_W-1:0] merge(input logic [P_W-1:0] s, input logic [P_W-1:0] c,
                                           input logic [P_W-1:0] m, input corr_t k);
    logic [P_W-1:0] adj;
    adj = (k == CORR_ADD) ? m : ((k == CORR_SUB) ? (~m + 1'b1) : '0);
    return s + c + adj;
  endfunction

  state_t          state_q;
  logic [P_W-1:0]  sum_q, carry_q, mcand_q, prod_q;
  logic [OP_W-1:0] rem_q, rem_sh;
  logic            cin_q, sgn_q, done_q;

  logic [P_W-1:0]  step_sum, step_carry;
  logic            term_w, accept_w, iter_w;
  corr_t           corr_w;

  term_detect #(.OP_W(OP_W)) u_term (
    .rem (rem_q),
    .sgn (sgn_q),
    .cin (cin_q),
    .term(term_w),
    .corr(corr_w)
  );

  csa_step #(.P_W(P_W), .STEP(STEP)) u_step (
    .sum_i  (sum_q),
    .carry_i(carry_q),
    .mcand  (mcand_q),
    .bits   (rem_q[STEP-1:0]),
    .cin    (cin_q),
    .sum_o  (step_sum),
    .carry_o(step_carry)
  );

  assign accept_w = start && (state_q == ST_IDLE);
  assign iter_w   = (state_q == ST_RUN) && !term_w;
  assign rem_sh   = sgn_q ? OP_W'($signed(rem_q) >>> STEP) : (rem_q >> STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sum_q   <= '0;
      carry_q <= '0;
      mcand_q <= '0;
      rem_q   <= '0;
      cin_q   <= 1'b0;
      sgn_q   <= 1'b0;
      prod_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_w) begin
        state_q <= ST_RUN;
        sum_q   <= acc_en ? acc_in : '0;
        carry_q <= '0;
        mcand_q <= sgn ? {{OP_W{op_a[OP_W-1]}}, op_a} : {{OP_W{1'b0}}, op_a};
        rem_q   <= op_b;
        cin_q   <= 1'b0;
        sgn_q   <= sgn;
      end else if (state_q == ST_RUN) begin
        if (term_w) begin
          prod_q  <= merge(sum_q, carry_q, mcand_q, corr_w);
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end else begin
          sum_q   <= step_sum;
          carry_q <= step_carry;
          mcand_q <= mcand_q << STEP;
          rem_q   <= rem_sh;
          cin_q   <= rem_q[STEP-1];
        end
      end
    end
  end

  assign busy    = (state_q == ST_RUN);
  assign done    = done_q;
  assign product = prod_q;

endmodule

// File: rtl/csa_iter_mul_chk.sv
module csa_iter_mul_chk #(
  parameter int OP_W = 32,
  parameter int STEP = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [2*OP_W-1:0] product,
  input logic              term_w,
  input logic              iter_w
);

  localparam int MAX_IT = OP_W / STEP;
  localparam int CW     = $clog2(MAX_IT + 2);

  logic [CW-1:0] it_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       it_cnt <= '0;
    else if (!busy)   it_cnt <= '0;
    else if (iter_w)  it_cnt <= it_cnt + 1'b1;
  end

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r6_done_not_busy:  assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r6_start_to_busy:  assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  a_r6_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n) (busy && term_w) |=> (done && !busy));
  a_r8_busy_holds:     assert property (@(posedge clk) disable iff (!rst_n) (busy && !term_w) |=> busy);
  a_r5_iter_bound:     assert property (@(posedge clk) disable iff (!rst_n) busy |-> (it_cnt <= CW'(MAX_IT)));
  a_r5_final_term:     assert property (@(posedge clk) disable iff (!rst_n) (busy && it_cnt == CW'(MAX_IT)) |-> term_w);
  a_r9_product_hold:   assert property (@(posedge clk) disable iff (!rst_n) (!done && $past(rst_n)) |-> $stable(product));

endmodule

bind csa_iter_mul csa_iter_mul_chk #(.OP_W(OP_W), .STEP(STEP)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .product(product),
  .term_w (term_w),
  .iter_w (iter_w)
);

// File: tb/tb_csa_iter_mul.sv
module tb_csa_iter_mul;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, sgn = 1'b0, acc_en = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [63:0] acc_in = '0;
  logic        busy, done;
  logic [63:0] product;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;  // 125 MHz

  csa_iter_mul dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sgn(sgn), .acc_en(acc_en),
    .op_a(op_a), .op_b(op_b), .acc_in(acc_in),
    .busy(busy), .done(done), .product(product)
  );

  function automatic logic [63:0] ref_prod(logic [31:0] a, logic [31:0] b, logic [63:0] acc,
                                           bit ae, bit sg);
    logic [63:0] p;
    if (sg) p = 64'($signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b}));
    else    p = {32'd0, a} * {32'd0, b};
    return ae ? p + acc : p;
  endfunction

  function automatic int ref_iters(logic [31:0] b, bit sg);
    logic [63:0] x, hi;
    x = sg ? {{32{b[31]}}, b} : {32'd0, b};
    for (int i = 0; i < 4; i++) begin
      hi = sg ? 64'($signed(x) >>> (8 * i)) : (x >> (8 * i));
      if (hi == 64'd0 || (sg && hi == '1)) return i;
    end
    return 4;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(logic [31:0] a, logic [31:0] b, logic [63:0] acc, bit ae, bit sg, bit poke);
    int c, n;
    logic [63:0] exp;
    string req;
    n   = ref_iters(b, sg);
    exp = ref_prod(a, b, acc, ae, sg);
    req = ae ? "R4" : (sg ? "R3" : "R2");
    @(negedge clk);
    op_a = a; op_b = b; acc_in = acc; acc_en = ae; sgn = sg; start = 1'b1;
    @(negedge clk);
    c = 1;
    chk(busy === 1'b1 && done === 1'b0, "R6", "busy after start", {62'd0, busy, done}, 64'd2);
    if (poke) begin
      op_a = ~a; op_b = b ^ 32'h5A5A_0F0F; acc_in = ~acc; sgn = ~sg;
    end else start = 1'b0;
    while (done !== 1'b1 && c < 20) begin
      @(negedge clk);
      c++;
      start = 1'b0;
    end
    chk(c == n + 2, "R5", "cycles to done", 64'(c), 64'(n + 2));
    chk(product === exp, req, "result", product, exp);
    chk(busy === 1'b0, "R6", "busy with done", {63'd0, busy}, 64'd0);
    @(negedge clk);
    chk(done === 1'b0, "R7", "done width", {63'd0, done}, 64'd0);
    chk(product === exp, "R9", "result held", product, exp);
    if (poke) chk(busy === 1'b0, "R8", "start while busy ignored", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] ra, rb;
    logic [63:0] racc;
    int mode;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1", "reset flags", {62'd0, busy, done}, 64'd0);
    chk(product === 64'd0, "R1", "reset product", product, 64'd0);
    rst_n = 1'b1;

    // directed corners
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 1'b0, 1'b0, 1'b0);        // R2 full length
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 1'b0, 1'b1, 1'b0);        // R3 early exit n=0
    run_op(32'h8000_0000, 32'h8000_0000, 64'd0, 1'b0, 1'b1, 1'b0);        // R3 most negative
    run_op(32'h1234_5678, 32'h0000_0000, 64'd0, 1'b0, 1'b0, 1'b0);        // R5 zero multiplier
    run_op(32'h1234_5678, 32'h0000_00FF, 64'd0, 1'b0, 1'b0, 1'b0);        // R5 one byte
    run_op(32'hDEAD_BEEF, 32'h0080_0000, 64'd0, 1'b0, 1'b1, 1'b0);        // R5 n=3 signed
    run_op(32'h0000_0007, 32'hFFFF_FF80, 64'd0, 1'b0, 1'b1, 1'b0);        // R3 small negative
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0); // R4 wrap
    run_op(32'h0000_1000, 32'h0000_0010, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, 1'b0); // R4 acc ignored
    run_op(32'hCAFE_F00D, 32'h7654_3210, 64'h1111, 1'b0, 1'b0, 1'b1);     // R8 poke

    for (int i = 0; i < 400; i++) begin
      ra   = $urandom();
      rb   = $urandom();
      racc = {$urandom(), $urandom()};
      mode = int'($urandom_range(0, 3));
      case (mode)
        0: rb = rb >> (8 * $urandom_range(1, 3));
        1: rb = rb | (32'hFFFF_FFFF << (8 * $urandom_range(1, 3)));
        default: ;
      endcase
      run_op(ra, rb, racc, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             ($urandom_range(0, 9) == 0));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule